// File: doc/BRIEF.md
# Register-Mapped Interrupt Router

This block gathers a small set of level-sensitive interrupt lines and turns them into two request outputs for a processor: a normal interrupt request and a fast interrupt request. Software controls it through a simple synchronous register bus. The bus has a byte address, a write strobe, write data, and read data that is available in the same cycle. The interrupt mask can only be changed through two registers. One sets mask bits and the other clears them, so a driver can change one line without a read-modify-write.

Each line passes through a conditioning stage first. A select bit chooses between the live input wires and a writable test word. Then the lines that are wired for it, bits 4 and 5 by default, can have their sense inverted so that they are active-low. The conditioned lines form the raw pending word. That word, ANDed with the mask, is the status word that software reads. A per-line route bit sends each masked pending line either to the normal output or to the fast output. Both outputs are registered. Pending bits are never latched: clearing an interrupt means removing its cause at the source.

Top module: `intr_router`

## Requirements
- R1: Writing the set-enable register (byte offset 0x08) sets every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Reading 0x08 returns the mask. Write-data bits above the line count are ignored.
- R2: Writing the clear-enable register (byte offset 0x0C) clears every mask bit whose write-data bit is 1 and leaves the other mask bits unchanged. Reading 0x0C returns 0.
- R3: Reading offset 0x04 returns the conditioned pending lines (bit i is line i) whatever the mask is. Reading offset 0x00 returns that word ANDed with the mask.
- R4: The route register (0x14) has one bit per line, where 0 sends the line to `irq_o` and 1 sends it to `fiq_o`. On each clock edge, `irq_o` takes the OR of the masked pending bits whose route bit is 0, and `fiq_o` takes the OR of those whose route bit is 1. Each output therefore changes one edge after its cause.
- R5: In the polarity register (0x18), a 1 in bit 4 or bit 5 inverts that line before masking, making it active-low. A 0 keeps it active-high.
- R6: Polarity bits for lines other than 4 and 5 are not stored (they read back 0) and have no effect on the pending word.
- R7: When bit 0 of the source-select register (0x10) is 1, the lines come from the test word (0x1C) and `line_in` is ignored. When it is 0, the lines come from `line_in`. The polarity inversion applies to the selected source in both cases.
- R8: Pending bits follow their sources in the same cycle with no latching. A line that drops stops showing in status at once, and it stops showing at the outputs after the next edge.
- R9: A clock edge with `rst_n` low clears the mask, the route, polarity, select and test registers, and both outputs.
- R10: Addresses at or above 0x20, and addresses whose two low bits are not 00, read as 0 and ignore writes.
- R11: Writes to the status (0x00) and raw (0x04) offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W (6) | Byte address of the register access |
| bus_we | input | 1 | Write strobe, taken at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| line_in | input | NUM_LINES (10) | Live level-sensitive interrupt lines |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench uses the default build: ten lines, with lines 4 and 5 invertible. With ten lines, all 1024 input words can be swept. For each input word the bench writes a different mask and route word, and it predicts the status, raw, normal and fast outputs arithmetically. The small build also allows exhaustive passes over all four polarity settings of the invertible pair, and over all 1024 test-source words. Outside the sweeps, the bench places directed checks on the one-edge output latency, the absence of latching, aliased and misaligned addresses, and a reset taken in the middle of a run.

// File: rtl/irt_pkg.sv
`timescale 1ns/1ps
// Package irt_pkg: defaults and register selector shared by the interrupt
// router modules. Assumes a 32-bit data bus and word-aligned registers.
package irt_pkg;
    localparam int unsigned IRT_LINES_DEF  = 10;
    localparam int unsigned IRT_ADDR_W_DEF = 6;
    localparam int unsigned IRT_DATA_W     = 32;
    // Lines whose sense may be inverted (bits 4 and 5 by default)
    localparam logic [31:0] IRT_INV_DEF    = 32'h0000_0030;

    // Word index of each register (byte offset divided by four)
    typedef enum logic [2:0] {
        RG_STATUS  = 3'd0,
        RG_RAW     = 3'd1,
        RG_EN_SET  = 3'd2,
        RG_EN_CLR  = 3'd3,
        RG_SRC_SEL = 3'd4,
        RG_ROUTE   = 3'd5,
        RG_POL     = 3'd6,
        RG_TEST    = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;
endpackage

// File: rtl/irt_regs.sv
`timescale 1ns/1ps
// Module irt_regs: decodes the register bus, holds the mask, route,
// polarity, source-select and test words, and drives combinational read data.
// Assumes NUM_LINES < 32 and ADDR_W >= 6; misaligned or out-of-map
// addresses neither read nor write.
module irt_regs #(
    parameter int unsigned NUM_LINES = irt_pkg::IRT_LINES_DEF,
    parameter int unsigned ADDR_W    = irt_pkg::IRT_ADDR_W_DEF,
    parameter logic [31:0] INV_LINES = irt_pkg::IRT_INV_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [irt_pkg::IRT_DATA_W-1:0] bus_wdata,
    input  logic [NUM_LINES-1:0]           raw_pend,
    input  logic [NUM_LINES-1:0]           masked_pend,
    output logic [irt_pkg::IRT_DATA_W-1:0] bus_rdata,
    output logic [NUM_LINES-1:0]           en_mask,
    output logic                           src_sel,
    output logic [NUM_LINES-1:0]           test_src,
    output logic [NUM_LINES-1:0]           pol_bits,
    output logic [NUM_LINES-1:0]           route_bits
);
    import irt_pkg::*;

    localparam int unsigned PAD_W = IRT_DATA_W - NUM_LINES;
    localparam logic [NUM_LINES-1:0] POL_KEEP = INV_LINES[NUM_LINES-1:0];

    reg_dec_t                 dec;
    logic                     wr_hit;
    logic [NUM_LINES-1:0]     wd;
    logic [IRT_DATA_W-1:NUM_LINES] wdata_unused;
    logic [NUM_LINES-1:0]     rd_word;

    assign wd           = bus_wdata[NUM_LINES-1:0];
    assign wdata_unused = bus_wdata[IRT_DATA_W-1:NUM_LINES];

    // Address decode: aligned and inside the eight-word map
    always_comb begin
        dec.hit = (bus_addr[1:0] == 2'b00) && (bus_addr[ADDR_W-1:5] == '0);
        dec.sel = reg_sel_e'(bus_addr[4:2]);
    end

    assign wr_hit = bus_we && dec.hit;

    // Mask: set through one register, cleared through another
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_mask <= '0;
        end else if (wr_hit && dec.sel == RG_EN_SET) begin
            en_mask <= en_mask | wd;
        end else if (wr_hit && dec.sel == RG_EN_CLR) begin
            en_mask <= en_mask & ~wd;
        end
    end

    // Route word: per line, 0 selects normal output, 1 the fast output
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_bits <= '0;
        end else if (wr_hit && dec.sel == RG_ROUTE) begin
            route_bits <= wd;
        end
    end

    // Polarity word: only invertible lines keep a bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pol_bits <= '0;
        end else if (wr_hit && dec.sel == RG_POL) begin
            pol_bits <= wd & POL_KEEP;
        end
    end

    // Source select bit and test word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_sel  <= 1'b0;
            test_src <= '0;
        end else if (wr_hit) begin
            if (dec.sel == RG_SRC_SEL) src_sel  <= wd[0];
            if (dec.sel == RG_TEST)    test_src <= wd;
        end
    end

    // Read mux: zero for unmapped and write-only locations
    always_comb begin
        rd_word = '0;
        if (dec.hit) begin
            case (dec.sel)
                RG_STATUS:  rd_word = masked_pend;
                RG_RAW:     rd_word = raw_pend;
                RG_EN_SET:  rd_word = en_mask;
                RG_EN_CLR:  rd_word = '0;
                RG_SRC_SEL: rd_word = {{(NUM_LINES-1){1'b0}}, src_sel};
                RG_ROUTE:   rd_word = route_bits;
                RG_POL:     rd_word = pol_bits;
                RG_TEST:    rd_word = test_src;
                default:    rd_word = '0;
            endcase
        end
    end

    assign bus_rdata = {{PAD_W{1'b0}}, rd_word};
endmodule

// File: rtl/irt_cond.sv
`timescale 1ns/1ps
// Module irt_cond: picks live or test sources and applies the per-line
// polarity inversion. Purely combinational; lines not listed in INV_LINES
// are passed straight through.
module irt_cond #(
    parameter int unsigned NUM_LINES = irt_pkg::IRT_LINES_DEF,
    parameter logic [31:0] INV_LINES = irt_pkg::IRT_INV_DEF
) (
    input  logic [NUM_LINES-1:0] line_in,
    input  logic [NUM_LINES-1:0] test_src,
    input  logic                 src_sel,
    input  logic [NUM_LINES-1:0] pol_bits,
    output logic [NUM_LINES-1:0] raw_pend
);
    logic [NUM_LINES-1:0] src;

    // Source selection between live wires and the test word
    assign src = src_sel ? test_src : line_in;

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        if (INV_LINES[i]) begin : g_inv
            // Invertible line: polarity bit flips its sense
            assign raw_pend[i] = src[i] ^ pol_bits[i];
        end else begin : g_pass
            logic pol_unused;
            assign pol_unused  = pol_bits[i];
            assign raw_pend[i] = src[i];
        end
    end
endmodule

// File: rtl/irt_route.sv
`timescale 1ns/1ps
// Module irt_route: masks the pending lines and registers the two request
// outputs. Assumes pending inputs are level-sensitive; nothing is latched.
module irt_route #(
    parameter int unsigned NUM_LINES = irt_pkg::IRT_LINES_DEF
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_pend,
    input  logic [NUM_LINES-1:0] en_mask,
    input  logic [NUM_LINES-1:0] route_bits,
    output logic [NUM_LINES-1:0] masked_pend,
    output logic                 irq_o,
    output logic                 fiq_o
);
    logic irq_d;
    logic fiq_d;

    assign masked_pend = raw_pend & en_mask;

    // Split masked pending lines by route bit
    always_comb begin
        irq_d = |(masked_pend & ~route_bits);
        fiq_d = |(masked_pend &  route_bits);
    end

    // Output registers, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_o <= 1'b0;
            fiq_o <= 1'b0;
        end else begin
            irq_o <= irq_d;
            fiq_o <= fiq_d;
        end
    end
endmodule

// File: rtl/intr_router.sv
`timescale 1ns/1ps
// Module intr_router: register-mapped interrupt router with set/clear mask
// registers, per-line normal/fast routing, polarity for selected lines and a
// test-source substitute. Read data is combinational; outputs are registered.
module intr_router #(
    parameter int unsigned NUM_LINES = irt_pkg::IRT_LINES_DEF,
    parameter int unsigned ADDR_W    = irt_pkg::IRT_ADDR_W_DEF,
    parameter logic [31:0] INV_LINES = irt_pkg::IRT_INV_DEF
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [ADDR_W-1:0]              bus_addr,
    input  logic                           bus_we,
    input  logic [irt_pkg::IRT_DATA_W-1:0] bus_wdata,
    output logic [irt_pkg::IRT_DATA_W-1:0] bus_rdata,
    input  logic [NUM_LINES-1:0]           line_in,
    output logic                           irq_o,
    output logic                           fiq_o
);
    logic [NUM_LINES-1:0] en_mask;
    logic [NUM_LINES-1:0] route_bits;
    logic [NUM_LINES-1:0] pol_bits;
    logic [NUM_LINES-1:0] test_src;
    logic                 src_sel;
    logic [NUM_LINES-1:0] raw_pend;
    logic [NUM_LINES-1:0] masked_pend;

    irt_regs #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .INV_LINES(INV_LINES)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_addr    (bus_addr),
        .bus_we      (bus_we),
        .bus_wdata   (bus_wdata),
        .raw_pend    (raw_pend),
        .masked_pend (masked_pend),
        .bus_rdata   (bus_rdata),
        .en_mask     (en_mask),
        .src_sel     (src_sel),
        .test_src    (test_src),
        .pol_bits    (pol_bits),
        .route_bits  (route_bits)
    );

    irt_cond #(.NUM_LINES(NUM_LINES), .INV_LINES(INV_LINES)) u_cond (
        .line_in  (line_in),
        .test_src (test_src),
        .src_sel  (src_sel),
        .pol_bits (pol_bits),
        .raw_pend (raw_pend)
    );

    irt_route #(.NUM_LINES(NUM_LINES)) u_route (
        .clk         (clk),
        .rst_n       (rst_n),
        .raw_pend    (raw_pend),
        .en_mask     (en_mask),
        .route_bits  (route_bits),
        .masked_pend (masked_pend),
        .irq_o       (irq_o),
        .fiq_o       (fiq_o)
    );
endmodule

// File: rtl/irt_checker.sv
`timescale 1ns/1ps
// Module irt_checker: temporal properties of intr_router, bound to it below.
module irt_checker #(
    parameter int unsigned NUM_LINES = irt_pkg::IRT_LINES_DEF,
    parameter int unsigned ADDR_W    = irt_pkg::IRT_ADDR_W_DEF
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic [ADDR_W-1:0]              bus_addr,
    input logic                           bus_we,
    input logic [NUM_LINES-1:0]           wd,
    input logic [irt_pkg::IRT_DATA_W-1:0] bus_rdata,
    input logic                           irq_o,
    input logic                           fiq_o,
    input logic [NUM_LINES-1:0]           en_mask,
    input logic [NUM_LINES-1:0]           route_bits,
    input logic [NUM_LINES-1:0]           raw_pend,
    input logic [NUM_LINES-1:0]           masked_pend
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(8'h00);
    localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(8'h08);
    localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(8'h0C);
    localparam logic [ADDR_W-1:0] A_END    = ADDR_W'(8'h20);

    a_r1_set_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET) |=> ((en_mask & $past(wd)) == $past(wd)));

    a_r1_keep_others: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_SET) |=>
        ((en_mask & ~$past(wd)) == ($past(en_mask) & ~$past(wd))));

    a_r2_clear_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_CLR) |=> ((en_mask & $past(wd)) == '0));

    a_r3_status_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_STATUS) |->
        (((bus_rdata[NUM_LINES-1:0] & ~en_mask) == '0) &&
         ((bus_rdata[NUM_LINES-1:0] & ~raw_pend) == '0)));

    a_r4_irq_route: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_o == $past(|(masked_pend & ~route_bits))));

    a_r4_fiq_route: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (fiq_o == $past(|(masked_pend & route_bits))));

    a_r9_reset_outputs: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !fiq_o));

    a_r10_unmapped_read: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_addr[1:0] != 2'b00) || (bus_addr >= A_END)) |-> (bus_rdata == '0));
endmodule

bind intr_router irt_checker #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_we      (bus_we),
    .wd          (bus_wdata[NUM_LINES-1:0]),
    .bus_rdata   (bus_rdata),
    .irq_o       (irq_o),
    .fiq_o       (fiq_o),
    .en_mask     (en_mask),
    .route_bits  (route_bits),
    .raw_pend    (raw_pend),
    .masked_pend (masked_pend)
);

// File: tb/sim_intr_router.sv
`timescale 1ns/1ps
// Bench sim_intr_router: sweeps inputs, masks, routes, polarity and test
// source on the default ten-line build and predicts every result itself.
module sim_intr_router;
    localparam int N = 10;
    localparam logic [5:0] A_STATUS = 6'h00, A_RAW = 6'h04, A_SET = 6'h08,
                           A_CLR = 6'h0C, A_SEL = 6'h10, A_ROUTE = 6'h14,
                           A_POL = 6'h18, A_TEST = 6'h1C;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [5:0]  bus_addr;
    logic        bus_we;
    logic [31:0] bus_wdata;
    logic [31:0] bus_rdata;
    logic [N-1:0] line_in;
    logic        irq_o;
    logic        fiq_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    intr_router u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .line_in(line_in),
        .irq_o(irq_o), .fiq_o(fiq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] v);
        @(negedge clk);
        bus_addr = a;
        #1 v = bus_rdata;
    endtask

    task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // Watchdog: a hung run ends as a failure
    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] v;
        rst_n = 1'b0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0; line_in = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state of every register and output
        for (int a = 0; a < 8; a++) rd_chk("R9 reset register", 6'(a * 4), 32'h0);
        chk("R9 irq_o after reset", {31'b0, irq_o}, 32'h0);
        chk("R9 fiq_o after reset", {31'b0, fiq_o}, 32'h0);

        // R1: set-enable
        wr(A_SET, 32'h005);      rd_chk("R1 set bits", A_SET, 32'h005);
        wr(A_SET, 32'h300);      rd_chk("R1 others kept", A_SET, 32'h305);
        wr(A_SET, 32'hFFFF_F000); rd_chk("R1 high data ignored", A_SET, 32'h305);
        // R2: clear-enable
        wr(A_CLR, 32'h004);      rd_chk("R2 clear bit", A_SET, 32'h301);
        rd_chk("R2 clear reads zero", A_CLR, 32'h0);

        // R11: writes to status and raw change nothing
        wr(A_STATUS, 32'h3FF); wr(A_RAW, 32'h3FF);
        rd_chk("R11 mask kept", A_SET, 32'h301);
        rd_chk("R11 route kept", A_ROUTE, 32'h0);
        rd_chk("R11 test kept", A_TEST, 32'h0);
        rd_chk("R11 select kept", A_SEL, 32'h0);

        // R10: aliases and misaligned addresses
        wr(6'h28, 32'h0FF); wr(6'h09, 32'h0FF); wr(6'h3C, 32'h3FF);
        rd_chk("R10 alias write ignored", A_SET, 32'h301);
        rd_chk("R10 alias test untouched", A_TEST, 32'h0);
        rd_chk("R10 read 0x28", 6'h28, 32'h0);
        rd_chk("R10 read 0x09", 6'h09, 32'h0);
        rd_chk("R10 read 0x3C", 6'h3C, 32'h0);

        // R4 latency and R8 no latching on line 0
        wr(A_CLR, 32'h3FF); wr(A_SET, 32'h001);
        @(negedge clk); bus_addr = A_STATUS;
        @(negedge clk); line_in = 10'h001;
        #1;
        chk("R8 status follows at once", bus_rdata, 32'h001);
        chk("R4 irq_o not before edge", {31'b0, irq_o}, 32'h0);
        @(negedge clk);
        chk("R4 irq_o one edge later", {31'b0, irq_o}, 32'h1);
        line_in = 10'h000;
        #1;
        chk("R8 status drops at once", bus_rdata, 32'h0);
        chk("R8 irq_o holds until edge", {31'b0, irq_o}, 32'h1);
        @(negedge clk);
        chk("R8 irq_o drops after edge", {31'b0, irq_o}, 32'h0);

        // R3/R4: every input word with varied mask and route
        for (int i = 0; i < 1024; i++) begin
            logic [N-1:0] m, r, exp_st;
            m = N'(i * 13 + 5);
            r = N'(i * 7 + 3);
            exp_st = N'(i) & m;
            line_in = N'(i);
            wr(A_CLR, 32'h3FF); wr(A_SET, {22'b0, m}); wr(A_ROUTE, {22'b0, r});
            @(negedge clk);
            rd_chk("R3 status", A_STATUS, {22'b0, exp_st});
            rd_chk("R3 raw", A_RAW, 32'(i));
            chk("R4 irq_o", {31'b0, irq_o}, {31'b0, |(exp_st & ~r)});
            chk("R4 fiq_o", {31'b0, fiq_o}, {31'b0, |(exp_st & r)});
        end

        // R5: all polarity settings of lines 4 and 5, all inputs
        wr(A_ROUTE, 32'h0);
        for (int p = 0; p < 4; p++) begin
            wr(A_POL, 32'(p << 4));
            rd_chk("R5 polarity readback", A_POL, 32'(p << 4));
            for (int i = 0; i < 1024; i++) begin
                line_in = N'(i);
                rd_chk("R5 inverted raw", A_RAW, 32'(i ^ (p << 4)));
            end
        end

        // R6: polarity bits of other lines ignored
        wr(A_POL, 32'h3CF);
        rd_chk("R6 not stored", A_POL, 32'h0);
        line_in = 10'h2A5;
        rd_chk("R6 no effect", A_RAW, 32'h2A5);
        wr(A_POL, 32'h3FF);
        rd_chk("R6 only 4 and 5 kept", A_POL, 32'h030);
        rd_chk("R6 only 4 and 5 invert", A_RAW, 32'h2A5 ^ 32'h030);

        // R7: test source replaces live lines
        wr(A_POL, 32'h0); wr(A_SEL, 32'h1);
        rd_chk("R7 select readback", A_SEL, 32'h1);
        line_in = 10'h3FF;
        for (int t = 0; t < 1024; t++) begin
            wr(A_TEST, 32'(t));
            rd_chk("R7 raw from test word", A_RAW, 32'(t));
        end
        wr(A_TEST, 32'h0); wr(A_POL, 32'h030);
        rd_chk("R7 polarity on test word", A_RAW, 32'h030);
        wr(A_POL, 32'h0); wr(A_SET, 32'h3FF); wr(A_ROUTE, 32'h200); wr(A_TEST, 32'h200);
        @(negedge clk);
        chk("R7 test word drives fiq_o", {31'b0, fiq_o}, 32'h1);
        chk("R7 test word irq_o idle", {31'b0, irq_o}, 32'h0);
        wr(A_SEL, 32'h0);
        line_in = 10'h155;
        rd_chk("R7 live lines back", A_RAW, 32'h155);

        // R9: reset in mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; line_in = '0;
        for (int a = 0; a < 8; a++) rd_chk("R9 mid-run reset register", 6'(a * 4), 32'h0);
        chk("R9 irq_o cleared", {31'b0, irq_o}, 32'h0);
        chk("R9 fiq_o cleared", {31'b0, fiq_o}, 32'h0);

        summary();
        $finish;
    end
endmodule